// File: doc/BRIEF.md
# SPI Register-Access Master with CRC8

This block runs one register transaction per request against an SPI peripheral that exposes 24-bit registers behind a 7-bit address. A request carries the address, a read flag, 24 bits of write data and a flag that turns CRC protection on. The block builds the frame and shifts it out in SPI mode 0. It captures the reply and, when protection is on, either appends a checksum byte (writes) or checks the checksum byte returned by the peripheral (reads).

The request side uses a valid/ready handshake. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is fully idle. It drops in the cycle after acceptance and stays low through the frame and the chip-select recovery gap. A requester may hold `req_valid` with stable fields for as long as it likes. A `req_valid` pulse seen while `req_ready` is low is not stored. Results use plain pins: `done` pulses once per frame, and `rd_data`/`crc_err` keep their values until the next `done`.

Top module: `spi_reg_master`

## Requirements
- R1: The first byte on MOSI is the command byte: address in bits [7:1] and the access flag in bit 0 (1 = read, 0 = write). It is followed on writes by the 24 data bits, and every field is sent MSB first.
- R2: SCLK idles low (SPI mode 0). MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and each SCLK half-period lasts CLK_DIV system clocks, so a frame of N bits holds chip-select low for exactly 2·N·CLK_DIV cycles with SCLK high for N·CLK_DIV of them.
- R3: A frame has 32 SCLK pulses with CRC off and 40 with CRC on, for both reads and writes.
- R4: On a CRC-enabled write, the last 8 bits are the CRC8 of the command byte followed by data bytes [23:16], [15:8], [7:0]. The CRC starts at 0x00 and takes each byte bit 0 first; when (bit XOR crc[0]) is 1 the register becomes (crc>>1) XOR 0x8C, otherwise crc>>1.
- R5: On a read, MOSI is low for every bit after the command byte, and `rd_data` returns the 24 bits received right after the command byte.
- R6: On a CRC-enabled read, the CRC of R4 is computed over the sent command byte and the three received data bytes and compared with the received 8-bit checksum; `crc_err` is 1 exactly when they differ. It is 0 after writes and after reads without CRC.
- R7: Chip-select stays low for the whole frame and rises in the cycle after the last SCLK falling edge. `done` is high for exactly that one cycle, and SCLK is low whenever chip-select is high.
- R8: After chip-select rises it stays high for at least 2·CLK_DIV system clocks before the next frame. `req_ready` and `busy` are inverses, and `req_ready` stays low from acceptance until that gap has ended.
- R9: A request is taken only on a cycle with `req_valid` and `req_ready` both high; a `req_valid` pulse while `req_ready` is low starts no frame.
- R10: After reset, chip-select is high, SCLK and MOSI are low, `req_ready` is high, and `busy`, `done`, `rd_data` and `crc_err` are 0.
- R11: `rd_data` and `crc_err` change only in the `done` cycle; a write sets `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_addr | input | 7 | Register address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 24 | Write data |
| req_crc_en | input | 1 | Add/check the CRC8 byte |
| busy | output | 1 | Frame or recovery gap in progress |
| done | output | 1 | One-cycle pulse when chip-select is released |
| rd_data | output | 24 | Data from the last completed frame |
| crc_err | output | 1 | Checksum mismatch on the last read |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |

## Verification
A peripheral model in the bench records MOSI on each rising SCLK and plays a prepared reply on MISO. The bench sends plain writes, CRC writes, plain reads, and CRC reads with a correct and with a corrupted checksum. These tell apart frame length (32 vs 40), command encoding, and the zeroing of MOSI on reads. They also show whether the checksum is taken over received rather than transmitted data. The bench also holds a request across back-to-back frames to measure the chip-select gap, pulses `req_valid` mid-frame to show it is dropped, and watches `rd_data` during a later write to show the hold rule.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } xfer_state_e;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

  // one byte folded into the running checksum, bit 0 first
  function automatic logic [7:0] crc8_fold(input logic [7:0] crc_in,
                                           input logic [7:0] byte_in);
    logic [7:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (byte_in[i] ^ c[0]) c = (c >> 1) ^ CRC_POLY_REFL;
      else                   c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_crc8.sv
module spi_crc8 #(
  parameter int NBYTES = 4,
  localparam int MSG_W = 8 * NBYTES
) (
  input  logic [MSG_W-1:0] msg,
  output logic [7:0]       crc
);
  import spi_reg_pkg::*;

  logic [7:0] stage [0:NBYTES];

  assign stage[0] = 8'h00;

  // bytes taken from the most significant end first
  for (genvar g = 0; g < NBYTES; g++) begin : g_fold
    assign stage[g+1] = crc8_fold(stage[g], msg[MSG_W-1-8*g -: 8]);
  end

  assign crc = stage[NBYTES];
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int CLK_DIV = 2,
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);
  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             at_end;

  assign at_end   = (cnt_q == CNT_W'(CLK_DIV - 1));
  assign rise_stb = en && at_end && !sclk_q;
  assign fall_stb = en && at_end &&  sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  sclk_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk);
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 24,
  localparam int CMD_W     = ADDR_W + 1,
  localparam int BASE_BITS = CMD_W + DATA_W,
  localparam int MAX_BITS  = BASE_BITS + 8,
  localparam int RX_W      = DATA_W + 8,
  localparam int NBYTES    = BASE_BITS / 8,
  localparam int BCNT_W    = $clog2(MAX_BITS + 1),
  localparam int GAP_CYC   = 2 * CLK_DIV,
  localparam int GAP_W     = $clog2(GAP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_crc_en,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              crc_err,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  import spi_reg_pkg::*;

  xfer_state_e         state_q;
  logic                cs_n_q;
  logic [MAX_BITS-1:0] tx_sr_q;
  logic [RX_W-1:0]     rx_sr_q;
  logic [BCNT_W-1:0]   bit_cnt_q;
  logic [BCNT_W-1:0]   last_bit_q;
  logic [GAP_W-1:0]    gap_cnt_q;
  logic [CMD_W-1:0]    cmd_q;
  logic                rd_q;
  logic                crc_en_q;
  logic [DATA_W-1:0]   rd_data_q;
  logic                crc_err_q;
  logic                done_q;

  logic                accept;
  logic                rise_stb;
  logic                fall_stb;
  logic [CMD_W-1:0]    tx_cmd;
  logic [7:0]          tx_crc;
  logic [7:0]          rx_crc_calc;
  logic [DATA_W-1:0]   rx_data_w;
  logic [MAX_BITS-1:0] frame_w;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign tx_cmd = {req_addr, req_rd};

  spi_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (state_q == ST_SHIFT),
    .sclk     (spi_sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  spi_crc8 #(.NBYTES(NBYTES)) u_tx_crc (
    .msg (BASE_BITS'({tx_cmd, req_wdata})),
    .crc (tx_crc)
  );

  spi_crc8 #(.NBYTES(NBYTES)) u_rx_crc (
    .msg (BASE_BITS'({cmd_q, rx_sr_q[8 +: DATA_W]})),
    .crc (rx_crc_calc)
  );

  // frame image, left-justified; reads send zeros after the command
  always_comb begin
    if (req_rd)          frame_w = {tx_cmd, {(MAX_BITS-CMD_W){1'b0}}};
    else if (req_crc_en) frame_w = {tx_cmd, req_wdata, tx_crc};
    else                 frame_w = {tx_cmd, req_wdata, 8'h00};
  end

  assign rx_data_w = crc_en_q ? rx_sr_q[8 +: DATA_W] : rx_sr_q[0 +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cs_n_q     <= 1'b1;
      tx_sr_q    <= '0;
      rx_sr_q    <= '0;
      bit_cnt_q  <= '0;
      last_bit_q <= '0;
      gap_cnt_q  <= '0;
      cmd_q      <= '0;
      rd_q       <= 1'b0;
      crc_en_q   <= 1'b0;
      rd_data_q  <= '0;
      crc_err_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q    <= ST_SHIFT;
            cs_n_q     <= 1'b0;
            tx_sr_q    <= frame_w;
            rx_sr_q    <= '0;
            bit_cnt_q  <= '0;
            last_bit_q <= req_crc_en ? BCNT_W'(MAX_BITS - 1) : BCNT_W'(BASE_BITS - 1);
            cmd_q      <= tx_cmd;
            rd_q       <= req_rd;
            crc_en_q   <= req_crc_en;
          end
        end
        ST_SHIFT: begin
          if (rise_stb) rx_sr_q <= {rx_sr_q[RX_W-2:0], spi_miso};
          if (fall_stb) begin
            tx_sr_q <= {tx_sr_q[MAX_BITS-2:0], 1'b0};
            if (bit_cnt_q == last_bit_q) begin
              state_q   <= ST_GAP;
              cs_n_q    <= 1'b1;
              done_q    <= 1'b1;
              gap_cnt_q <= '0;
              rd_data_q <= rd_q ? rx_data_w : '0;
              crc_err_q <= rd_q && crc_en_q && (rx_sr_q[7:0] != rx_crc_calc);
            end else begin
              bit_cnt_q <= bit_cnt_q + BCNT_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt_q == GAP_W'(GAP_CYC - 1)) state_q <= ST_IDLE;
          else gap_cnt_q <= gap_cnt_q + GAP_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_ready = !busy;
  assign done      = done_q;
  assign rd_data   = rd_data_q;
  assign crc_err   = crc_err_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_mosi  = (state_q == ST_SHIFT) && tx_sr_q[MAX_BITS-1];

  // ---------------- assertions ----------------
  logic [GAP_W-1:0] cs_high_mon_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cs_high_mon_q <= GAP_W'(GAP_CYC);
    else if (!spi_cs_n)                       cs_high_mon_q <= '0;
    else if (cs_high_mon_q < GAP_W'(GAP_CYC)) cs_high_mon_q <= cs_high_mon_q + GAP_W'(1);
  end

  // R7
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R7
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(!spi_cs_n)));

  // R2
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R9
  accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !spi_cs_n));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_high_mon_q >= GAP_W'(GAP_CYC)));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_data) && $stable(crc_err)));
endmodule

// File: tb/tb_spi_reg_master.sv
`timescale 1ns/1ps
module tb_spi_reg_master;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_addr = '0;
  logic        req_rd = 1'b0;
  logic [23:0] req_wdata = '0;
  logic        req_crc_en = 1'b0;
  logic        busy, done, crc_err;
  logic [23:0] rd_data;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  spi_reg_master #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .req_wdata(req_wdata),
    .req_crc_en(req_crc_en), .busy(busy), .done(done), .rd_data(rd_data),
    .crc_err(crc_err), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [31:0] m);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] by = m[31-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        if (by[i] ^ c[0]) c = (c >> 1) ^ 8'h8C;
        else              c = c >> 1;
      end
    end
    return c;
  endfunction

  // peripheral model and bus monitor
  logic [39:0] slv_resp = '0;
  logic [39:0] cap, last_cap;
  int nb, last_nb, low_cyc, last_low, hi_cyc, last_hi;
  int frames = 0, gap_run = 0, min_gap = 1000000;
  int mosi_viol = 0, idle_viol = 0, done_bad = 0;
  bit seen_frame = 0;

  initial begin
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
    int idx = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_cs && !spi_cs_n) begin
          cap = '0; nb = 0; low_cyc = 0; hi_cyc = 0;
          spi_miso = slv_resp[39]; idx = 38;
          if (seen_frame && gap_run < min_gap) min_gap = gap_run;
        end
        if (!spi_cs_n) begin
          low_cyc++;
          if (spi_sclk) hi_cyc++;
          if (!prev_sclk && spi_sclk) begin cap = {cap[38:0], spi_mosi}; nb++; end
          if (prev_sclk && !spi_sclk && idx >= 0) begin spi_miso = slv_resp[idx]; idx--; end
          if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) mosi_viol++;
        end
        if (!prev_cs && spi_cs_n) begin
          frames++; last_cap = cap; last_nb = nb; last_low = low_cyc; last_hi = hi_cyc;
          seen_frame = 1; gap_run = 0;
        end
        if (spi_cs_n) gap_run++;
        if (spi_cs_n && spi_sclk) idle_viol++;
        if (done && !(spi_cs_n && !prev_cs)) done_bad++;
      end
      prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
    end
  end

  task automatic issue(input logic [6:0] a, input logic rd, input logic [23:0] d, input logic ce);
    @(negedge clk);
    req_addr = a; req_rd = rd; req_wdata = d; req_crc_en = ce; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);   // let the monitor record the frame
  endtask

  task automatic t_reset();
    chk("R10 cs_n", spi_cs_n, 1); chk("R10 sclk", spi_sclk, 0);
    chk("R10 mosi", spi_mosi, 0); chk("R10 ready", req_ready, 1);
    chk("R10 busy", busy, 0); chk("R10 done", done, 0);
    chk("R10 rd_data", rd_data, 0); chk("R10 crc_err", crc_err, 0);
  endtask

  task automatic t_write_plain();
    issue(7'h2A, 1'b0, 24'h5AC30F, 1'b0);
    wait_done();
    chk("R1 write frame", last_cap[31:0], {8'h54, 24'h5AC30F});
    chk("R3 plain length", last_nb, 32);
    chk("R2 cs low cycles", last_low, 64*DIV);
    chk("R2 sclk high cycles", last_hi, 32*DIV);
    chk("R11 write clears rd_data", rd_data, 0);
    chk("R6 no err on write", crc_err, 0);
  endtask

  task automatic t_write_crc();
    issue(7'h43, 1'b0, 24'hFA3E80, 1'b1);
    wait_done();
    chk("R3 crc length", last_nb, 40);
    chk("R4 write crc frame", last_cap, {8'h86, 24'hFA3E80, ref_crc({8'h86, 24'hFA3E80})});
    chk("R2 cs low cycles crc", last_low, 80*DIV);
  endtask

  task automatic t_read_plain();
    slv_resp = {8'h00, 24'h123456, 8'h00};
    issue(7'h24, 1'b1, 24'hFFFFFF, 1'b0);
    wait_done();
    chk("R5 read mosi low, R1 cmd", last_cap[31:0], {8'h49, 24'h0});
    chk("R5 read data", rd_data, 24'h123456);
    chk("R6 no err plain read", crc_err, 0);
    chk("R3 read length", last_nb, 32);
  endtask

  task automatic t_read_crc(input bit corrupt);
    logic [7:0] c = ref_crc({8'h43, 24'hBD934B});
    slv_resp = {8'h00, 24'hBD934B, corrupt ? (c ^ 8'h01) : c};
    issue(7'h21, 1'b1, 24'h0, 1'b1);
    wait_done();
    chk("R5 crc read mosi low", last_cap, {8'h43, 32'h0});
    chk("R3 crc read length", last_nb, 40);
    chk("R5 crc read data", rd_data, 24'hBD934B);
    chk("R6 crc_err", crc_err, corrupt);
  endtask

  task automatic t_hold();
    issue(7'h05, 1'b0, 24'h000111, 1'b1);
    repeat (30) @(negedge clk);
    chk("R11 rd_data held mid-frame", rd_data, 24'hBD934B);
    chk("R11 crc_err held mid-frame", crc_err, 1);
    chk("R8 busy mid-frame", busy, 1);
    wait_done();
    chk("R11 rd_data after write", rd_data, 0);
    chk("R6 crc_err after write", crc_err, 0);
  endtask

  task automatic t_ignore();
    int f0 = frames;
    issue(7'h11, 1'b0, 24'hABCDEF, 1'b0);
    repeat (20) @(negedge clk);
    req_addr = 7'h7F; req_wdata = 24'h0; req_valid = 1'b1;
    chk("R8 ready low in frame", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (4*DIV + 10) @(negedge clk);
    chk("R9 one frame only", frames - f0, 1);
    chk("R9 frame content", last_cap[31:0], {8'h22, 24'hABCDEF});
    chk("R8 idle after gap", req_ready, 1);
  endtask

  task automatic t_b2b();
    int f0 = frames;
    min_gap = 1000000;
    issue(7'h01, 1'b0, 24'h111111, 1'b0);
    issue(7'h02, 1'b0, 24'h222222, 1'b0);
    wait_done();
    chk("R8 two frames", frames - f0, 2);
    chk("R8 gap >= 2*div", min_gap >= 2*DIV, 1);
    chk("R1 second frame", last_cap[31:0], {8'h04, 24'h222222});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_plain();
    t_write_crc();
    t_read_plain();
    t_read_crc(1'b0);
    t_read_crc(1'b1);
    t_hold();
    t_ignore();
    t_b2b();
    chk("R2 mosi stable while sclk high", mosi_viol, 0);
    chk("R7 sclk low while cs high", idle_viol, 0);
    chk("R7 done only at release", done_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule